// File: doc/BRIEF.md
# Memory-Mapped Portal Message Endpoint Hub

This block sits between a simple host register bus and application logic. It carries small messages in both directions. The hub holds several endpoints. Each endpoint owns one register window.

In the software-to-hardware direction, every method has its own block of argument slots. Software fills the slots with programmed-I/O writes. Writing the last argument word of a method commits the message, and it is then shown to the hardware as a method number plus all argument words, under a valid/ready handshake. This direction has no flow control. A commit that arrives while the previous message is still waiting is discarded, and only its method number is kept for debug readback.

In the hardware-to-software direction, application logic pushes messages into a small FIFO per endpoint and is held off while that FIFO is full. Software polls a status word, or enables an interrupt that is raised while a message is waiting. The interrupts of all endpoints are ORed onto one line. Window 0 is a directory that lists the numeric ID of each endpoint, so software can find the window it needs.

Top module: `portal_hub`

## Requirements
- R1: Writing the final argument word (word NARGS-1) of method m at window offset m*NARGS+NARGS-1 raises req_valid on the next cycle, provided nothing is held or the held message is taken in that cycle. At that point req_meth=m and argument word a sits at req_args bits [a*32 +: 32]. The non-final words come from the most recent write to that method's slots, even if that write was made during an earlier message.
- R2: While req_valid is high and req_ready is low, req_valid, req_meth and req_args stay unchanged. The cycle after a handshake, req_valid falls, unless a new message was committed in that same cycle.
- R3: A commit made while a message is held and req_ready is low is dropped, and the held message is not changed. The drop register (offset 10) then reads bit 31 = 1, with the dropped method number in its low bits. A commit in the same cycle as the handshake is accepted and is not a drop.
- R4: Any write to offset 10 clears the drop register to zero.
- R5: ind_ready is high while the indication FIFO holds fewer than DEPTH messages and low when it is full. Each handshake stores one message, and messages leave in arrival order. A push and a pop in the same cycle keep the count unchanged.
- R6: Status (offset 8) reads bit 0 = a message is waiting, with the message count in bits [15:8].
- R7: Offset 11 reads the head method number. Offset 12+a reads head argument word a. Reading offset 12+NARGS-1 also removes the head message. When the FIFO is empty, these reads return 0 and remove nothing.
- R8: Offset 9 bit 0 is a read/write interrupt enable. An endpoint's interrupt is its enable AND a message waiting. The irq output is the OR of all endpoints' interrupts.
- R9: Window 0 offset 0 reads the endpoint count. Window 0 offset 1+j reads the 16-bit ID of endpoint j, which lives at window j+1 (address bits [5:4] select the window, bits [3:0] the word).
- R10: bus_rdata is loaded on the clock edge that samples bus_rd and holds its value between reads.
- R11: After reset: req_valid low, every FIFO empty, ind_ready high, interrupt enables and drop registers clear, irq low, bus_rdata zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Word address: window select and offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| req_valid | output | NPORT | Request message valid, per endpoint |
| req_ready | input | NPORT | Hardware accepts request, per endpoint |
| req_meth | output | NPORT*2 | Request method number, per endpoint |
| req_args | output | NPORT*64 | Request argument words, per endpoint |
| ind_valid | input | NPORT | Indication offered by hardware |
| ind_ready | output | NPORT | Indication FIFO has room |
| ind_meth | input | NPORT*2 | Indication method number |
| ind_args | input | NPORT*64 | Indication argument words |
| irq | output | 1 | Combined interrupt |

## Verification
Two sets of events can land on the same clock edge. A software commit can coincide with the hardware taking the held request. A software read that pops the head indication can coincide with a hardware push. The bench lines up both pairs on purpose, by raising req_ready or ind_valid in the very cycle the bus strobe is driven. It then checks that the new request is taken rather than recorded as a drop, and that the FIFO count and head order come out as a queue model predicts. Random request and indication traffic, checked against bench-side models, runs around these directed cases.

// File: rtl/portal_pkg.sv
package portal_pkg;
  // word offsets inside one endpoint window
  localparam int WIN_BITS   = 4;
  localparam int OFF_STATUS = 8;
  localparam int OFF_IRQEN  = 9;
  localparam int OFF_DROP   = 10;
  localparam int OFF_HEAD   = 11;
  localparam int OFF_IARG   = 12;

  // request slot index of (method, argument word)
  function automatic int slot_of(int meth, int arg, int nargs);
    return meth * nargs + arg;
  endfunction

  // circular pointer advance
  function automatic int ptr_inc(int p, int depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // status word: count in [15:8], pending in bit 0
  function automatic logic [31:0] status_word(int cnt);
    logic [31:0] w;
    w = '0;
    w[15:8] = 8'(cnt);
    w[0] = (cnt != 0);
    return w;
  endfunction
endpackage

// File: rtl/portal_req.sv
module portal_req
  import portal_pkg::*;
#(
  parameter int NMETH = 4,
  parameter int NARGS = 2,
  parameter int DW    = 32,
  localparam int MW   = (NMETH > 1) ? $clog2(NMETH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [WIN_BITS-1:0]   off,
  input  logic [DW-1:0]         wdata,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [MW-1:0]         req_meth,
  output logic [NARGS*DW-1:0]   req_args,
  output logic [DW-1:0]         drop_word
);
  localparam int NSLOT = NMETH * NARGS;

  logic [DW-1:0]       stage [NMETH][NARGS];
  logic                slot_hit, commit_ev, accept_ev, drop_ev;
  logic [MW-1:0]       hit_meth;
  int                  hit_arg, oi;
  logic [NARGS*DW-1:0] commit_args;
  logic                drop_seen;
  logic [MW-1:0]       drop_meth;

  always_comb begin
    oi        = int'(off);
    slot_hit  = wr_en && (oi < NSLOT);
    hit_meth  = MW'(oi / NARGS);
    hit_arg   = oi % NARGS;
    commit_ev = slot_hit && (hit_arg == NARGS - 1);
    for (int a = 0; a < NARGS; a++) begin
      commit_args[a*DW +: DW] = (a == NARGS - 1) ? wdata : stage[hit_meth][a];
    end
  end

  assign accept_ev = commit_ev && (!req_valid || req_ready);
  assign drop_ev   = commit_ev && !accept_ev;

  // per-method argument staging
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int m = 0; m < NMETH; m++)
        for (int a = 0; a < NARGS; a++)
          stage[m][a] <= '0;
    end else if (slot_hit) begin
      stage[hit_meth][hit_arg] <= wdata;
    end
  end

  // single holding register toward the hardware
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_meth  <= '0;
      req_args  <= '0;
    end else begin
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (accept_ev) begin
        req_valid <= 1'b1;
        req_meth  <= hit_meth;
        req_args  <= commit_args;
      end
    end
  end

  // debug record of the last dropped method
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_seen <= 1'b0;
      drop_meth <= '0;
    end else if (drop_ev) begin
      drop_seen <= 1'b1;
      drop_meth <= hit_meth;
    end else if (wr_en && off == WIN_BITS'(OFF_DROP)) begin
      drop_seen <= 1'b0;
      drop_meth <= '0;
    end
  end

  always_comb begin
    drop_word           = '0;
    drop_word[DW-1]     = drop_seen;
    drop_word[MW-1:0]   = drop_meth;
  end

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_meth) && $stable(req_args));

  // R3
  drop_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> drop_seen && drop_meth == $past(hit_meth) && $stable(req_args));
endmodule

// File: rtl/portal_ind_fifo.sv
module portal_ind_fifo
  import portal_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int EW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  output logic          push_ready,
  input  logic [EW-1:0] push_data,
  input  logic          pop,
  output logic [EW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty
);
  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          push_ev, pop_ev;

  assign push_ready = (count < CW'(DEPTH));
  assign empty      = (count == '0);
  assign push_ev    = push_valid && push_ready;
  assign pop_ev     = pop && !empty;
  assign head       = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ev) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ev) wp <= PW'(ptr_inc(int'(wp), DEPTH));
      if (pop_ev)  rp <= PW'(ptr_inc(int'(rp), DEPTH));
      count <= count + CW'(push_ev) - CW'(pop_ev);
    end
  end

  // R5
  fill_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev && !pop_ev |=> count == $past(count) + 1'b1);

  // R7
  pop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev && !push_ev && count == CW'(1) |=> empty);
endmodule

// File: rtl/portal_endpoint.sv
module portal_endpoint
  import portal_pkg::*;
#(
  parameter int NMETH = 4,
  parameter int NARGS = 2,
  parameter int DW    = 32,
  parameter int DEPTH = 2,
  localparam int MW   = (NMETH > 1) ? $clog2(NMETH) : 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int EW   = MW + NARGS * DW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [WIN_BITS-1:0] off,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rd_val,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [MW-1:0]       req_meth,
  output logic [NARGS*DW-1:0] req_args,
  input  logic                ind_valid,
  output logic                ind_ready,
  input  logic [MW-1:0]       ind_meth,
  input  logic [NARGS*DW-1:0] ind_args,
  output logic                irq_o
);
  logic [DW-1:0]       drop_word;
  logic [EW-1:0]       head;
  logic [CW-1:0]       count;
  logic                empty, pop_rd, irq_en;
  logic [MW-1:0]       head_meth;
  logic [NARGS*DW-1:0] head_args;
  int                  oi;

  portal_req #(.NMETH(NMETH), .NARGS(NARGS), .DW(DW)) u_req (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .off(off), .wdata(wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_meth(req_meth),
    .req_args(req_args), .drop_word(drop_word)
  );

  assign pop_rd = rd_en && (off == WIN_BITS'(OFF_IARG + NARGS - 1));

  portal_ind_fifo #(.DEPTH(DEPTH), .EW(EW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_valid(ind_valid), .push_ready(ind_ready),
    .push_data({ind_meth, ind_args}), .pop(pop_rd), .head(head),
    .count(count), .empty(empty)
  );

  assign head_meth = head[EW-1 -: MW];
  assign head_args = head[NARGS*DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) irq_en <= 1'b0;
    else if (wr_en && off == WIN_BITS'(OFF_IRQEN)) irq_en <= wdata[0];
  end

  assign irq_o = irq_en && !empty;

  always_comb begin
    oi     = int'(off);
    rd_val = '0;
    if (oi == OFF_STATUS) begin
      rd_val[0]       = !empty;
      rd_val[8 +: CW] = count;
    end else if (oi == OFF_IRQEN) begin
      rd_val[0] = irq_en;
    end else if (oi == OFF_DROP) begin
      rd_val = drop_word;
    end else if (oi == OFF_HEAD) begin
      if (!empty) rd_val[MW-1:0] = head_meth;
    end else if (oi >= OFF_IARG && oi < OFF_IARG + NARGS && !empty) begin
      rd_val = head_args[(oi - OFF_IARG)*DW +: DW];
    end
  end

  // R8
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_en && off == WIN_BITS'(OFF_IRQEN) && wdata[0] && !empty |=> irq_o);
endmodule

// File: rtl/portal_hub.sv
module portal_hub
  import portal_pkg::*;
#(
  parameter int NPORT = 2,
  parameter int NMETH = 4,
  parameter int NARGS = 2,
  parameter int DW    = 32,
  parameter int DEPTH = 2,
  parameter logic [NPORT*16-1:0] PORT_IDS = {16'h00A1, 16'h005C},
  localparam int MW     = (NMETH > 1) ? $clog2(NMETH) : 1,
  localparam int SEL_W  = $clog2(NPORT + 1),
  localparam int ADDR_W = SEL_W + WIN_BITS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DW-1:0]             bus_wdata,
  output logic [DW-1:0]             bus_rdata,
  output logic [NPORT-1:0]          req_valid,
  input  logic [NPORT-1:0]          req_ready,
  output logic [NPORT*MW-1:0]       req_meth,
  output logic [NPORT*NARGS*DW-1:0] req_args,
  input  logic [NPORT-1:0]          ind_valid,
  output logic [NPORT-1:0]          ind_ready,
  input  logic [NPORT*MW-1:0]       ind_meth,
  input  logic [NPORT*NARGS*DW-1:0] ind_args,
  output logic                      irq
);
  logic [SEL_W-1:0]    sel;
  logic [WIN_BITS-1:0] off;
  logic [DW-1:0]       ep_rd [NPORT];
  logic [NPORT-1:0]    ep_irq;
  logic [DW-1:0]       dir_val, rd_mux;
  int                  si, oi;

  assign sel = bus_addr[ADDR_W-1:WIN_BITS];
  assign off = bus_addr[WIN_BITS-1:0];

  for (genvar j = 0; j < NPORT; j++) begin : g_ep
    portal_endpoint #(.NMETH(NMETH), .NARGS(NARGS), .DW(DW), .DEPTH(DEPTH)) u_ep (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr && sel == SEL_W'(j + 1)),
      .rd_en(bus_rd && sel == SEL_W'(j + 1)),
      .off(off), .wdata(bus_wdata), .rd_val(ep_rd[j]),
      .req_valid(req_valid[j]), .req_ready(req_ready[j]),
      .req_meth(req_meth[j*MW +: MW]), .req_args(req_args[j*NARGS*DW +: NARGS*DW]),
      .ind_valid(ind_valid[j]), .ind_ready(ind_ready[j]),
      .ind_meth(ind_meth[j*MW +: MW]), .ind_args(ind_args[j*NARGS*DW +: NARGS*DW]),
      .irq_o(ep_irq[j])
    );
  end

  // interrupt mux
  assign irq = |ep_irq;

  // directory window and read mux
  always_comb begin
    si      = int'(sel);
    oi      = int'(off);
    dir_val = '0;
    if (oi == 0) dir_val = DW'(NPORT);
    else if (oi <= NPORT) dir_val[15:0] = PORT_IDS[(oi - 1)*16 +: 16];
    rd_mux = '0;
    if (si == 0) rd_mux = dir_val;
    else if (si <= NPORT) rd_mux = ep_rd[si - 1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R9
  dir_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && sel == '0 && off == '0 |=> bus_rdata == DW'(NPORT));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/portal_hub_bench.sv
module portal_hub_bench;
  localparam int NP = 2;
  localparam int AW = 64;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NP-1:0]  req_valid, ind_ready;
  logic [NP-1:0]  req_ready = '0, ind_valid = '0;
  logic [NP*2-1:0]  req_meth;
  logic [NP*2-1:0]  ind_meth = '0;
  logic [NP*AW-1:0] req_args;
  logic [NP*AW-1:0] ind_args = '0;
  logic           irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  portal_hub u_portal_hub (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_meth(req_meth),
    .req_args(req_args), .ind_valid(ind_valid), .ind_ready(ind_ready),
    .ind_meth(ind_meth), .ind_args(ind_args), .irq(irq)
  );

  function automatic logic [5:0] ep_addr(int p, int o);
    return 6'(((p + 1) << 4) | o);
  endfunction

  function automatic logic [31:0] exp_status(int cnt);
    return (32'(cnt) << 8) | 32'(cnt != 0);
  endfunction

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bwr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ind_push(int p, logic [1:0] m, logic [63:0] a);
    @(negedge clk);
    ind_valid[p] = 1'b1; ind_meth[p*2 +: 2] = m; ind_args[p*AW +: AW] = a;
    while (!ind_ready[p]) @(negedge clk);
    @(negedge clk);
    ind_valid[p] = 1'b0;
  endtask

  task automatic send_req(int p, int m, logic [31:0] a0, logic [31:0] a1);
    bwr(ep_addr(p, m*2), a0);
    bwr(ep_addr(p, m*2 + 1), a1);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] qa [$];
    logic [1:0]  qm [$];
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 req_valid", 64'(req_valid), 0);
    chk("R11 ind_ready", 64'(ind_ready), 64'(2'b11));
    chk("R11 irq", 64'(irq), 0);
    chk("R11 rdata", 64'(bus_rdata), 0);
    brd(ep_addr(0, 10), rd); chk("R11 drop clear", 64'(rd), 0);

    // R9 directory
    brd(6'd0, rd); chk("R9 count", 64'(rd), 2);
    brd(6'd1, rd); chk("R9 id0", 64'(rd), 64'h5C);
    brd(6'd2, rd); chk("R9 id1", 64'(rd), 64'hA1);
    // R10 holds across a write
    bwr(ep_addr(1, 9), 32'h0);
    chk("R10 hold", 64'(bus_rdata), 64'hA1);

    // R1 directed commit on endpoint 0, method 2
    send_req(0, 2, 32'h1111_2222, 32'h3333_4444);
    chk("R1 valid", 64'(req_valid[0]), 1);
    chk("R1 meth", 64'(req_meth[1:0]), 2);
    chk("R1 args", req_args[63:0], 64'h3333_4444_1111_2222);
    // R2 holds
    repeat (3) @(negedge clk);
    chk("R2 hold", {req_valid[0], req_meth[1:0], req_args[60:0]},
        {1'b1, 2'd2, 61'h3333_4444_1111_2222});
    // R3 drop while held
    send_req(0, 1, 32'hDEAD, 32'hBEEF);
    chk("R3 unchanged", req_args[63:0], 64'h3333_4444_1111_2222);
    brd(ep_addr(0, 10), rd); chk("R3 drop id", 64'(rd), 64'h8000_0001);
    // R4 clear
    bwr(ep_addr(0, 10), 32'h0);
    brd(ep_addr(0, 10), rd); chk("R4 cleared", 64'(rd), 0);
    // R3 commit coincident with handshake: accepted
    bwr(ep_addr(0, 6), 32'hAAAA_0000);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ep_addr(0, 7); bus_wdata = 32'hBBBB_0000;
    req_ready[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; req_ready[0] = 1'b0;
    chk("R3 same-cycle valid", 64'(req_valid[0]), 1);
    chk("R3 same-cycle meth", 64'(req_meth[1:0]), 3);
    chk("R3 same-cycle args", req_args[63:0], 64'hBBBB_0000_AAAA_0000);
    brd(ep_addr(0, 10), rd); chk("R3 no drop", 64'(rd), 0);
    @(negedge clk); req_ready[0] = 1'b1;
    @(negedge clk); req_ready[0] = 1'b0;
    chk("R2 drained", 64'(req_valid[0]), 0);
    // R1 staging retained: write only the final word of method 3
    bwr(ep_addr(0, 7), 32'hCCCC_0001);
    chk("R1 staged word", req_args[63:0], 64'hCCCC_0001_AAAA_0000);
    @(negedge clk); req_ready[0] = 1'b1;
    @(negedge clk); req_ready[0] = 1'b0;

    // R1 random requests
    for (int i = 0; i < 20; i++) begin
      int p, m;
      logic [31:0] a0, a1;
      p = $urandom_range(0, 1); m = $urandom_range(0, 3);
      a0 = $urandom; a1 = $urandom;
      send_req(p, m, a0, a1);
      chk("R1 rand valid", 64'(req_valid[p]), 1);
      chk("R1 rand msg", {62'(req_meth[p*2 +: 2]), 2'b0} ^ req_args[p*AW +: AW],
          {62'(m), 2'b0} ^ {a1, a0});
      @(negedge clk); req_ready[p] = 1'b1;
      @(negedge clk); req_ready[p] = 1'b0;
      chk("R2 rand drain", 64'(req_valid[p]), 0);
    end

    // R5 fill endpoint 1 and observe backpressure
    ind_push(1, 2'd1, 64'h0101_0101_0202_0202);
    ind_push(1, 2'd3, 64'h0303_0303_0404_0404);
    @(negedge clk);
    ind_valid[1] = 1'b1; ind_meth[3:2] = 2'd2;
    for (int c = 0; c < 3; c++) begin
      chk("R5 full stall", 64'(ind_ready[1]), 0);
      @(negedge clk);
    end
    ind_valid[1] = 1'b0;
    brd(ep_addr(1, 8), rd); chk("R6 status full", 64'(rd), 64'(exp_status(2)));
    // R8 gating and mux
    chk("R8 disabled", 64'(irq), 0);
    bwr(ep_addr(1, 9), 32'h1);
    chk("R8 enabled", 64'(irq), 1);
    brd(ep_addr(1, 9), rd); chk("R8 readback", 64'(rd), 1);
    // R7 head reads without pop, then pop
    brd(ep_addr(1, 11), rd); chk("R7 head meth", 64'(rd), 1);
    brd(ep_addr(1, 12), rd); chk("R7 arg0", 64'(rd), 64'h0202_0202);
    brd(ep_addr(1, 8), rd);  chk("R7 no pop", 64'(rd), 64'(exp_status(2)));
    brd(ep_addr(1, 13), rd); chk("R7 arg1 pop", 64'(rd), 64'h0101_0101);
    brd(ep_addr(1, 8), rd);  chk("R6 after pop", 64'(rd), 64'(exp_status(1)));
    // R5 push and pop in the same cycle
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ep_addr(1, 13);
    ind_valid[1] = 1'b1; ind_meth[3:2] = 2'd0; ind_args[127:64] = 64'h0909_0909_0808_0808;
    @(negedge clk);
    bus_rd = 1'b0; ind_valid[1] = 1'b0;
    chk("R5 coincident pop data", 64'(bus_rdata), 64'h0303_0303);
    brd(ep_addr(1, 8), rd);  chk("R5 coincident count", 64'(rd), 64'(exp_status(1)));
    brd(ep_addr(1, 11), rd); chk("R5 order head", 64'(rd), 0);
    brd(ep_addr(1, 13), rd); chk("R5 order arg1", 64'(rd), 64'h0909_0909);
    // R7 empty reads
    brd(ep_addr(1, 13), rd); chk("R7 empty read", 64'(rd), 0);
    brd(ep_addr(1, 8), rd);  chk("R6 empty", 64'(rd), 0);
    chk("R8 irq low when empty", 64'(irq), 0);

    // R5 R7 random traffic on endpoint 0 against a queue model
    for (int i = 0; i < 60; i++) begin
      if (($urandom_range(0, 1) == 1 && qm.size() < 2) || qm.size() == 0) begin
        logic [1:0] m; logic [63:0] a;
        m = 2'($urandom); a = {$urandom, $urandom};
        ind_push(0, m, a);
        qm.push_back(m); qa.push_back(a);
      end else begin
        logic [1:0] em; logic [63:0] ea;
        em = qm.pop_front(); ea = qa.pop_front();
        brd(ep_addr(0, 11), rd); chk("R7 rand head", 64'(rd), 64'(em));
        brd(ep_addr(0, 12), rd); chk("R7 rand arg0", 64'(rd), 64'(ea[31:0]));
        brd(ep_addr(0, 13), rd); chk("R5 rand arg1", 64'(rd), 64'(ea[63:32]));
      end
      @(negedge clk);
      chk("R5 rand ready", 64'(ind_ready[0]), 64'(qm.size() < 2));
    end
    brd(ep_addr(0, 8), rd); chk("R6 rand status", 64'(rd), 64'(exp_status(qm.size())));

    summary();
  end
endmodule